// File: doc/BRIEF.md
# Machine-Level Trap and Interrupt Controller

This block holds the trap state of a single hardware thread running at machine level, with a user level below it. It sits beside the pipeline. Each cycle, the pipeline may present a synchronous exception with its code and trap value, a return-from-trap request, a wait-for-interrupt request or a CSR access. Three interrupt lines (software, timer, external) arrive from outside.

In the same cycle the controller decides whether a trap, an interrupt or a return is taken. When one is taken, it raises a redirect with the target PC. The state update (saved PC, cause, trap value, enable stack, privilege) lands on the next clock edge as one atomic step.

A wake output tells a stalled core that an enabled interrupt is pending. With interrupts globally disabled, that wake does not turn into a trap: the core simply resumes at the next instruction. A parameter selects whether the handler base may be put in vectored mode, where interrupts branch to base plus four times their code.

Top module: `mtrap_ctrl`

## Requirements
- R1: After reset the privilege is machine (`priv_o` = 2'b11), the status register reads 0, the handler base reads 0, and neither `redirect_valid_o` nor `wake_o` is asserted.
- R2: A synchronous exception redirects in the same cycle to the handler base. On the next edge it has these effects: the saved PC becomes `inst_pc_i` with bits 1:0 cleared; the cause reads {0, code}; the trap value reads `exc_tval_i`; the status bit 7 (previous enable) takes the global enable (bit 3) and bit 3 clears; status bits 12:11 (previous privilege) take the old privilege; the privilege becomes machine.
- R3: An interrupt is taken only when status bit 3 is 1 and, for the same source, both the enable bit and the pending bit are 1. The sources sit at bit 3 (software), bit 7 (timer) and bit 11 (external) of both registers. When taken, the cause reads 0x80000000 | code, the trap value reads 0, the saved PC is `next_pc_i` with bits 1:0 cleared, and the enable stack and privilege update as in R2.
- R4: A synchronous exception wins over an interrupt in the same cycle. Among interrupts, external (11) wins over software (3), which wins over timer (7).
- R5: If the handler base register has mode field (bits 1:0) equal to 1, an interrupt redirects to base + 4 × code. Exceptions always go to the base itself, as do interrupts when the mode field is 0.
- R6: A return from trap in machine mode redirects to the saved PC. On the next edge the global enable takes the previous-enable bit, the privilege takes the previous-privilege field, the previous-enable bit becomes 1 and the previous-privilege field becomes user (00).
- R7: After a wait-for-interrupt request, `wake_o` is high in every cycle in which (enable AND pending) is nonzero, until that happens once. If status bit 3 is 0 at that time, no redirect occurs and the trap state is unchanged.
- R8: In user mode, a return-from-trap request or any CSR access raises an illegal-instruction exception (code 2) with trap value 0. Any write in that cycle is discarded.
- R9: The enable register keeps only bits 3, 7 and 11. The pending register is read-only and mirrors the three lines. The saved PC and the handler base read with bits 1:0 / bit 1 as zero. A previous-privilege write other than 11 stores 00. The registers sit at these addresses: status 0x300, enable 0x304, base 0x305, scratch 0x340, saved PC 0x341, cause 0x342, trap value 0x343, pending 0x344. Any other address reads 0.
- R10: A return request or CSR write in the same cycle as a taken interrupt is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | CODE_W | Exception cause code |
| exc_tval_i | input | XLEN | Exception trap value |
| inst_pc_i | input | XLEN | PC of the instruction presenting the request |
| next_pc_i | input | XLEN | Resume PC used when an interrupt is taken |
| irq_soft_i | input | 1 | Software interrupt line |
| irq_timer_i | input | 1 | Timer interrupt line |
| irq_ext_i | input | 1 | External interrupt line |
| xret_i | input | 1 | Return-from-trap request |
| wfi_i | input | 1 | Wait-for-interrupt request |
| csr_en_i | input | 1 | CSR access in this cycle |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address (read mux follows it at all times) |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | Current value of the addressed CSR |
| redirect_valid_o | output | 1 | A trap, interrupt or return is taken this cycle |
| redirect_pc_o | output | XLEN | Target PC of the redirect |
| priv_o | output | 2 | Current privilege: 11 machine, 00 user |
| wake_o | output | 1 | Wait ends: enabled interrupt pending |

## Verification
Redirect valid, redirect PC, wake and the CSR read data are all combinational. Each is due in the same cycle as the stimulus that causes it. The saved state (privilege, status, cause, saved PC, trap value) shows on `priv_o` and `csr_rdata_o` one edge later.

The bench drives each cycle's inputs on the falling edge and checks the combinational outputs shortly afterward. It then applies the cycle's effect to its own model at the rising edge. As a result, any state change is first compared in the following cycle, exactly one register stage after its cause.

// File: rtl/mtu_pkg.sv
// Shared constants for the machine trap controller.
// Assumes a machine level plus one user level; no supervisor level.
package mtu_pkg;
    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_M = 2'b11;

    localparam logic [11:0] CSR_STATUS  = 12'h300;
    localparam logic [11:0] CSR_IENABLE = 12'h304;
    localparam logic [11:0] CSR_HBASE   = 12'h305;
    localparam logic [11:0] CSR_SCRATCH = 12'h340;
    localparam logic [11:0] CSR_EPC     = 12'h341;
    localparam logic [11:0] CSR_CAUSE   = 12'h342;
    localparam logic [11:0] CSR_TVAL    = 12'h343;
    localparam logic [11:0] CSR_IPEND   = 12'h344;

    localparam int SRC_SOFT  = 3;
    localparam int SRC_TIMER = 7;
    localparam int SRC_EXT   = 11;
    localparam int NUM_SRC   = 3;

    localparam int CODE_ILLEGAL = 2;

    localparam int ST_GIE  = 3;
    localparam int ST_PGIE = 7;
    localparam int ST_PPL  = 11;
endpackage

// File: rtl/mtu_irq_select.sv
// Interrupt gating and fixed-priority selection.
// Assumes source bit positions equal their cause codes; XLEN >= 12.
module mtu_irq_select #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 4
) (
    input  logic              gie_i,
    input  logic [XLEN-1:0]   enable_i,
    input  logic [XLEN-1:0]   pend_i,
    output logic              any_o,
    output logic              take_o,
    output logic [CODE_W-1:0] code_o
);
    import mtu_pkg::*;

    // Order from highest to lowest priority.
    localparam int PRIO [NUM_SRC] = '{SRC_EXT, SRC_SOFT, SRC_TIMER};

    logic [XLEN-1:0] live;

    // Per-source enable-and-pending, and whether any remains.
    always_comb begin
        live  = enable_i & pend_i;
        any_o = |live;
    end

    // Walk from lowest to highest priority so the highest one wins.
    always_comb begin
        code_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (live[PRIO[i]]) code_o = CODE_W'(PRIO[i]);
        end
        take_o = gie_i && any_o;
    end
endmodule

// File: rtl/mtu_target.sv
// Redirect target selection: saved PC on return, vectored slot for
// interrupts in mode 1, plain base otherwise. Assumes base is 4-aligned.
module mtu_target #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 4
) (
    input  logic              sel_ret_i,
    input  logic              is_int_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic              vec_mode_i,
    input  logic [XLEN-1:0]   epc_i,
    output logic [XLEN-1:0]   pc_o
);
    logic [XLEN-1:0] slot_pc;

    // Choose among return target, vectored slot and base.
    always_comb begin
        slot_pc = base_i + (XLEN'(code_i) << 2);
        if (sel_ret_i)                  pc_o = epc_i;
        else if (is_int_i && vec_mode_i) pc_o = slot_pc;
        else                            pc_o = base_i;
    end
endmodule

// File: rtl/mtu_csr_regs.sv
// Trap state registers and CSR read mux. Update priority inside a cycle:
// trap entry, then return, then software write; the caller guarantees
// at most one is active. Assumes XLEN >= 13 and CODE_W < XLEN.
module mtu_csr_regs #(
    parameter int XLEN      = 32,
    parameter int CODE_W    = 4,
    parameter bit VECTOR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_i,
    input  logic              trap_int_i,
    input  logic [CODE_W-1:0] trap_code_i,
    input  logic [XLEN-1:0]   trap_pc_i,
    input  logic [XLEN-1:0]   trap_tval_i,
    input  logic              ret_i,
    input  logic              wr_i,
    input  logic [11:0]       addr_i,
    input  logic [XLEN-1:0]   wdata_i,
    input  logic              irq_soft_i,
    input  logic              irq_timer_i,
    input  logic              irq_ext_i,
    output logic [XLEN-1:0]   rdata_o,
    output logic              gie_o,
    output logic [XLEN-1:0]   enable_o,
    output logic [XLEN-1:0]   pend_o,
    output logic [XLEN-1:0]   base_o,
    output logic              vec_mode_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [1:0]        priv_o,
    output logic [1:0]        ppl_o
);
    import mtu_pkg::*;

    localparam logic [XLEN-1:0] ALIGN4 = ~XLEN'(3);
    localparam logic [XLEN-1:0] IE_MASK =
        (XLEN'(1) << SRC_SOFT) | (XLEN'(1) << SRC_TIMER) | (XLEN'(1) << SRC_EXT);

    logic              gie_q, pgie_q;
    logic [1:0]        ppl_q, priv_q;
    logic [XLEN-1:0]   ie_q, base_q, epc_q, tval_q, scratch_q;
    logic              vec_q, cint_q;
    logic [CODE_W-1:0] ccode_q;
    logic              vec_wr;

    // Mode-field legalisation picked by the vectoring parameter.
    generate
        if (VECTOR_EN) begin : g_vec
            assign vec_wr = (wdata_i[1:0] == 2'b01);
        end else begin : g_novec
            assign vec_wr = 1'b0;
        end
    endgenerate

    // Pending bits mirror the interrupt lines.
    always_comb begin
        pend_o            = '0;
        pend_o[SRC_SOFT]  = irq_soft_i;
        pend_o[SRC_TIMER] = irq_timer_i;
        pend_o[SRC_EXT]   = irq_ext_i;
    end

    // Atomic trap entry, return, or software write of the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q     <= 1'b0;
            pgie_q    <= 1'b0;
            ppl_q     <= PRIV_U;
            priv_q    <= PRIV_M;
            ie_q      <= '0;
            base_q    <= '0;
            vec_q     <= 1'b0;
            epc_q     <= '0;
            cint_q    <= 1'b0;
            ccode_q   <= '0;
            tval_q    <= '0;
            scratch_q <= '0;
        end else if (trap_i) begin
            epc_q   <= trap_pc_i & ALIGN4;
            cint_q  <= trap_int_i;
            ccode_q <= trap_code_i;
            tval_q  <= trap_tval_i;
            pgie_q  <= gie_q;
            gie_q   <= 1'b0;
            ppl_q   <= priv_q;
            priv_q  <= PRIV_M;
        end else if (ret_i) begin
            gie_q  <= pgie_q;
            priv_q <= ppl_q;
            pgie_q <= 1'b1;
            ppl_q  <= PRIV_U;
        end else if (wr_i) begin
            case (addr_i)
                CSR_STATUS: begin
                    gie_q  <= wdata_i[ST_GIE];
                    pgie_q <= wdata_i[ST_PGIE];
                    ppl_q  <= (wdata_i[ST_PPL+1:ST_PPL] == PRIV_M) ? PRIV_M : PRIV_U;
                end
                CSR_IENABLE: ie_q <= wdata_i & IE_MASK;
                CSR_HBASE: begin
                    base_q <= wdata_i & ALIGN4;
                    vec_q  <= vec_wr;
                end
                CSR_SCRATCH: scratch_q <= wdata_i;
                CSR_EPC:     epc_q     <= wdata_i & ALIGN4;
                CSR_CAUSE: begin
                    cint_q  <= wdata_i[XLEN-1];
                    ccode_q <= wdata_i[CODE_W-1:0];
                end
                CSR_TVAL:    tval_q    <= wdata_i;
                default: ;
            endcase
        end
    end

    // Read mux following the address port.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            CSR_STATUS: begin
                rdata_o[ST_GIE]            = gie_q;
                rdata_o[ST_PGIE]           = pgie_q;
                rdata_o[ST_PPL+1:ST_PPL]   = ppl_q;
            end
            CSR_IENABLE: rdata_o = ie_q;
            CSR_HBASE:   rdata_o = base_q | XLEN'(vec_q);
            CSR_SCRATCH: rdata_o = scratch_q;
            CSR_EPC:     rdata_o = epc_q;
            CSR_CAUSE:   rdata_o = {cint_q, {(XLEN-1-CODE_W){1'b0}}, ccode_q};
            CSR_TVAL:    rdata_o = tval_q;
            CSR_IPEND:   rdata_o = pend_o;
            default:     rdata_o = '0;
        endcase
    end

    assign gie_o      = gie_q;
    assign enable_o   = ie_q;
    assign base_o     = base_q;
    assign vec_mode_o = vec_q;
    assign epc_o      = epc_q;
    assign priv_o     = priv_q;
    assign ppl_o      = ppl_q;
endmodule

// File: rtl/mtrap_ctrl.sv
// Machine-level trap controller top. Decides in the request cycle which
// of exception, interrupt or return is taken (in that priority), drives
// the redirect combinationally, and commits state on the next edge.
// Assumes at most one instruction request per cycle from the pipeline.
module mtrap_ctrl #(
    parameter int XLEN      = 32,
    parameter int CODE_W    = 4,
    parameter bit VECTOR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   exc_tval_i,
    input  logic [XLEN-1:0]   inst_pc_i,
    input  logic [XLEN-1:0]   next_pc_i,
    input  logic              irq_soft_i,
    input  logic              irq_timer_i,
    input  logic              irq_ext_i,
    input  logic              xret_i,
    input  logic              wfi_i,
    input  logic              csr_en_i,
    input  logic              csr_we_i,
    input  logic [11:0]       csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_pc_o,
    output logic [1:0]        priv_o,
    output logic              wake_o
);
    import mtu_pkg::*;

    logic              gie, vec_mode, any_pend, int_req;
    logic [XLEN-1:0]   enable, pend, base, epc;
    logic [1:0]        priv, ppl;
    logic [CODE_W-1:0] int_code, trap_code;
    logic              illegal, exc_take, int_take, ret_take, csr_wr;
    logic [XLEN-1:0]   trap_pc, trap_tval;
    logic              wait_q;

    mtu_irq_select #(.XLEN(XLEN), .CODE_W(CODE_W)) u_sel (
        .gie_i    (gie),
        .enable_i (enable),
        .pend_i   (pend),
        .any_o    (any_pend),
        .take_o   (int_req),
        .code_o   (int_code)
    );

    // Take decision: exception beats interrupt beats return beats write.
    always_comb begin
        illegal   = (priv == PRIV_U) && (xret_i || csr_en_i);
        exc_take  = exc_valid_i || illegal;
        int_take  = !exc_take && int_req;
        ret_take  = !exc_take && !int_take && xret_i;
        csr_wr    = !exc_take && !int_take && csr_en_i && csr_we_i;
        trap_code = exc_valid_i ? exc_code_i :
                    (illegal ? CODE_W'(CODE_ILLEGAL) : int_code);
        trap_pc   = exc_take ? inst_pc_i : next_pc_i;
        trap_tval = exc_valid_i ? exc_tval_i : '0;
    end

    mtu_csr_regs #(.XLEN(XLEN), .CODE_W(CODE_W), .VECTOR_EN(VECTOR_EN)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .trap_i      (exc_take || int_take),
        .trap_int_i  (int_take),
        .trap_code_i (trap_code),
        .trap_pc_i   (trap_pc),
        .trap_tval_i (trap_tval),
        .ret_i       (ret_take),
        .wr_i        (csr_wr),
        .addr_i      (csr_addr_i),
        .wdata_i     (csr_wdata_i),
        .irq_soft_i  (irq_soft_i),
        .irq_timer_i (irq_timer_i),
        .irq_ext_i   (irq_ext_i),
        .rdata_o     (csr_rdata_o),
        .gie_o       (gie),
        .enable_o    (enable),
        .pend_o      (pend),
        .base_o      (base),
        .vec_mode_o  (vec_mode),
        .epc_o       (epc),
        .priv_o      (priv),
        .ppl_o       (ppl)
    );

    mtu_target #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tgt (
        .sel_ret_i  (ret_take),
        .is_int_i   (int_take),
        .code_i     (trap_code),
        .base_i     (base),
        .vec_mode_i (vec_mode),
        .epc_i      (epc),
        .pc_o       (redirect_pc_o)
    );

    // Wait state: set by a wait request, cleared by a wake or any trap.
    always_ff @(posedge clk) begin
        if (!rst_n) wait_q <= 1'b0;
        else        wait_q <= !any_pend && !exc_take && (wait_q || wfi_i);
    end

    assign wake_o           = (wait_q || wfi_i) && any_pend;
    assign redirect_valid_o = exc_take || int_take || ret_take;
    assign priv_o           = priv;
endmodule

// File: rtl/mtu_chk.sv
// Property checker for the trap controller, attached by bind.
module mtu_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_take,
    input logic            int_take,
    input logic            ret_take,
    input logic            gie,
    input logic            any_pend,
    input logic            wake_o,
    input logic            redirect_valid_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic [XLEN-1:0] base,
    input logic [1:0]      priv_o,
    input logic [1:0]      ppl
);
    // R3
    int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> (gie && any_pend));
    // R2
    exc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (priv_o == 2'b11));
    // R5
    exc_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> (redirect_pc_o == base));
    // R4
    one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exc_take, int_take, ret_take}));
    // R6
    ret_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_take |=> (priv_o == $past(ppl)));
    // R7
    wfi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !gie && !exc_take && !ret_take) |-> !redirect_valid_o);
endmodule

bind mtrap_ctrl mtu_chk #(.XLEN(XLEN)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .exc_take         (exc_take),
    .int_take         (int_take),
    .ret_take         (ret_take),
    .gie              (gie),
    .any_pend         (any_pend),
    .wake_o           (wake_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .base             (base),
    .priv_o           (priv_o),
    .ppl              (ppl)
);

// File: tb/mtrap_ctrl_bench.sv
module mtrap_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 0;
    logic [3:0]  exc_code_i = 0;
    logic [31:0] exc_tval_i = 0, inst_pc_i = 0, next_pc_i = 0;
    logic        irq_soft_i = 0, irq_timer_i = 0, irq_ext_i = 0;
    logic        xret_i = 0, wfi_i = 0, csr_en_i = 0, csr_we_i = 0;
    logic [11:0] csr_addr_i = 0;
    logic [31:0] csr_wdata_i = 0;
    logic [31:0] csr_rdata_o, redirect_pc_o;
    logic        redirect_valid_o, wake_o;
    logic [1:0]  priv_o;

    int checks = 0, fails = 0;
    bit done = 0;

    // Model state
    logic [1:0]  m_priv, m_ppl;
    logic        m_gie, m_pgie, m_vec, m_cint, m_wait;
    logic [31:0] m_ie, m_base, m_epc, m_tval, m_scr;
    logic [3:0]  m_code;

    always #10 clk = ~clk;

    mtrap_ctrl u_mtrap_ctrl (.*);

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pend_vec();
        logic [31:0] p = 0;
        p[3] = irq_soft_i; p[7] = irq_timer_i; p[11] = irq_ext_i;
        return p;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        case (a)
            12'h300: return {19'b0, m_ppl, 3'b0, m_pgie, 3'b0, m_gie, 3'b0};
            12'h304: return m_ie;
            12'h305: return m_base | {31'b0, m_vec};
            12'h340: return m_scr;
            12'h341: return m_epc;
            12'h342: return {m_cint, 27'b0, m_code};
            12'h343: return m_tval;
            12'h344: return pend_vec();
            default: return 32'h0;
        endcase
    endfunction

    // Check outputs this cycle, then apply the cycle to the model at the edge.
    task automatic cyc();
        logic [31:0] ep;
        bit ill, et, it, rt;
        logic [3:0] ic;
        #2;
        ep  = m_ie & pend_vec();
        ill = (m_priv == 2'b00) && (xret_i || csr_en_i);
        et  = exc_valid_i || ill;
        it  = !et && m_gie && (ep != 0);
        ic  = ep[11] ? 4'd11 : (ep[3] ? 4'd3 : 4'd7);
        rt  = !et && !it && xret_i;
        chk(redirect_valid_o == (et || it || rt), "R3 redirect_valid",
            {31'b0, redirect_valid_o}, {31'b0, et || it || rt});
        if (et)      chk(redirect_pc_o == m_base, "R2 exception pc", redirect_pc_o, m_base);
        else if (it) chk(redirect_pc_o == (m_vec ? m_base + 4 * ic : m_base),
                         "R5 interrupt pc", redirect_pc_o, m_vec ? m_base + 4 * ic : m_base);
        else if (rt) chk(redirect_pc_o == m_epc, "R6 return pc", redirect_pc_o, m_epc);
        chk(wake_o == ((m_wait || wfi_i) && ep != 0), "R7 wake",
            {31'b0, wake_o}, {31'b0, (m_wait || wfi_i) && ep != 0});
        chk(priv_o == m_priv, "R6 priv", {30'b0, priv_o}, {30'b0, m_priv});
        chk(csr_rdata_o == m_read(csr_addr_i), "R9 csr_rdata", csr_rdata_o, m_read(csr_addr_i));
        @(posedge clk);
        if (et || it) begin
            m_epc  = (et ? inst_pc_i : next_pc_i) & ~32'd3;
            m_cint = it;
            m_code = exc_valid_i ? exc_code_i : (ill ? 4'd2 : ic);
            m_tval = exc_valid_i ? exc_tval_i : 0;
            m_pgie = m_gie; m_gie = 0; m_ppl = m_priv; m_priv = 2'b11;
        end else if (rt) begin
            m_gie = m_pgie; m_priv = m_ppl; m_pgie = 1; m_ppl = 2'b00;
        end else if (csr_en_i && csr_we_i) begin
            case (csr_addr_i)
                12'h300: begin
                    m_gie = csr_wdata_i[3]; m_pgie = csr_wdata_i[7];
                    m_ppl = (csr_wdata_i[12:11] == 2'b11) ? 2'b11 : 2'b00;
                end
                12'h304: m_ie = csr_wdata_i & 32'h888;
                12'h305: begin m_base = csr_wdata_i & ~32'd3; m_vec = (csr_wdata_i[1:0] == 2'b01); end
                12'h340: m_scr = csr_wdata_i;
                12'h341: m_epc = csr_wdata_i & ~32'd3;
                12'h342: begin m_cint = csr_wdata_i[31]; m_code = csr_wdata_i[3:0]; end
                12'h343: m_tval = csr_wdata_i;
                default: ;
            endcase
        end
        m_wait = (ep == 0) && !et && (m_wait || wfi_i);
        @(negedge clk);
    endtask

    task automatic idle();
        exc_valid_i = 0; xret_i = 0; wfi_i = 0; csr_en_i = 0; csr_we_i = 0;
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        idle(); csr_en_i = 1; csr_we_i = 1; csr_addr_i = a; csr_wdata_i = d; cyc(); idle();
    endtask

    task automatic peek(logic [11:0] a);
        idle(); csr_addr_i = a; cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog act=0 exp=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_priv = 2'b11; m_ppl = 0; m_gie = 0; m_pgie = 0; m_vec = 0; m_cint = 0; m_wait = 0;
        m_ie = 0; m_base = 0; m_epc = 0; m_tval = 0; m_scr = 0; m_code = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(priv_o == 2'b11 && !redirect_valid_o && !wake_o, "R1 reset outputs",
            {29'b0, redirect_valid_o, priv_o}, 32'h3);
        peek(12'h300); peek(12'h305);
        // R9: masking of enable, saved PC, previous privilege
        wr(12'h304, 32'hFFFF_FFFF); peek(12'h304);
        wr(12'h341, 32'h1234_5677); peek(12'h341);
        wr(12'h300, 32'h0000_0888); peek(12'h300);
        wr(12'h305, 32'h0000_0101); peek(12'h305);
        wr(12'h300, 32'h0000_0008);
        // R4: exception with external pending at the same time
        idle(); irq_ext_i = 1; exc_valid_i = 1; exc_code_i = 4'd3;
        exc_tval_i = 32'hCAFE_0001; inst_pc_i = 32'h0000_4006; cyc(); idle();
        peek(12'h342); peek(12'h341); peek(12'h343); peek(12'h300);
        // R6: return re-enables, interrupt follows; R5 vectored slot 11
        xret_i = 1; cyc(); idle();
        next_pc_i = 32'h0000_5000; cyc(); peek(12'h342);
        // R4: software beats timer
        irq_ext_i = 0; wr(12'h300, 32'h0000_0008);
        irq_soft_i = 1; irq_timer_i = 1; cyc(); irq_soft_i = 0; irq_timer_i = 0;
        // R10: interrupt discards return and write in same cycle
        wr(12'h300, 32'h0000_1808);
        irq_timer_i = 1; xret_i = 1; csr_en_i = 1; csr_we_i = 1; csr_addr_i = 12'h340;
        csr_wdata_i = 32'hDEAD_BEEF; cyc(); idle(); irq_timer_i = 0; peek(12'h340);
        // R7: wait with global enable off, wake without redirect
        wr(12'h300, 32'h0); wfi_i = 1; cyc(); idle(); cyc();
        irq_timer_i = 1; cyc(); irq_timer_i = 0; cyc();
        // R8: drop to user then illegal write
        wr(12'h341, 32'h0000_7000); wr(12'h300, 32'h0);
        xret_i = 1; cyc(); idle();
        csr_en_i = 1; csr_we_i = 1; csr_addr_i = 12'h340; csr_wdata_i = 32'h1; inst_pc_i = 32'h7000;
        cyc(); idle(); peek(12'h340); peek(12'h342);
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int sel;
            idle();
            irq_soft_i  = ($urandom % 4) == 0;
            irq_timer_i = ($urandom % 4) == 0;
            irq_ext_i   = ($urandom % 6) == 0;
            inst_pc_i   = $urandom; next_pc_i = $urandom;
            sel = $urandom % 20;
            if (sel == 0) begin
                exc_valid_i = 1; exc_code_i = 4'($urandom % 12); exc_tval_i = $urandom;
            end else if (sel < 3) xret_i = 1;
            else if (sel < 5) wfi_i = 1;
            else if (sel < 12) begin
                csr_en_i = ($urandom % 3) != 0; csr_we_i = 1;
            end
            case ($urandom % 9)
                0: csr_addr_i = 12'h300; 1: csr_addr_i = 12'h304; 2: csr_addr_i = 12'h305;
                3: csr_addr_i = 12'h340; 4: csr_addr_i = 12'h341; 5: csr_addr_i = 12'h342;
                6: csr_addr_i = 12'h343; 7: csr_addr_i = 12'h344; default: csr_addr_i = 12'h7C0;
            endcase
            csr_wdata_i = $urandom;
            if (csr_addr_i == 12'h305 && ($urandom % 2)) csr_wdata_i[1:0] = 2'b01;
            cyc();
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule